// File: doc/BRIEF.md
# Double-buffered DAC input register

This block sits between an 8-bit write bus and a 10-bit digital-to-analog converter. Software writes a high byte and a low byte into holding registers. The converter never sees those registers directly. It is driven by a shadow register that the bus cannot reach, and the shadow is only refreshed as a whole 10-bit value. A half-written value therefore never reaches the converter.

There are two ways to refresh the shadow. In immediate mode, a write to the high byte loads the shadow at once. In triggered mode, a rising edge on one of several external trigger lines loads the shadow. A select field picks which line is used. The data is left-adjusted, so software that only needs 8 bits can write the high byte and ignore the low byte.

For a full 10-bit update, software writes the low byte first and the high byte second. The low byte is committed together with the high-byte write. A low byte written on its own stays in waiting until the next high-byte write.

Top module: `dac_dbuf`

## Requirements
- R1: A write is accepted on the rising clock edge when `wr_en` is 1. Address 0 selects the low byte and address 1 selects the high byte.
- R2: The output is left-adjusted. `dac_out[9:2]` carries the committed high byte, and `dac_out[1:0]` carries bits 7:6 of the committed low byte. Bits 5:0 of the low byte are never used.
- R3: In immediate mode (`trig_mode` = 0), a high-byte write loads the shadow from the written byte and the currently held low byte. The new value appears on `dac_out` right after that clock edge.
- R4: A low-byte write on its own never changes `dac_out`, in either mode.
- R5: In triggered mode (`trig_mode` = 1), a high-byte write does not change `dac_out`.
- R6: In triggered mode, a rising edge on `trig_in[trig_sel]` loads the shadow. Each line passes through a two-flop synchronizer before edge detection. If the line first reads high at clock edge k, `dac_out` changes after edge k+2. Holding the line high causes no further loads, and edges on lines that are not selected have no effect.
- R7: Every trigger reloads the shadow from the pair committed by the most recent high-byte write. Repeated high-byte writes followed by triggers give working 8-bit operation.
- R8: A low byte written after the last high-byte write is not used by a trigger. The trigger uses the low byte that was committed at the last high-byte write.
- R9: If a high-byte write and a selected trigger event fall in the same cycle, the shadow takes the newly written value.
- R10: Synchronous active-high reset clears the holding registers and the shadow to zero. Writes made while reset is high are discarded.
- R11: Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register address (0 = low byte, 1 = high byte) |
| wr_data | input | 8 | Write data |
| trig_mode | input | 1 | 1 = shadow loads on trigger, 0 = loads on high-byte write |
| trig_sel | input | 3 | Index of the trigger line in use |
| trig_in | input | 8 | Asynchronous trigger lines |
| dac_out | output | 10 | Shadow register driving the converter |

## Verification
A high-byte write and a trigger pulse on the selected line can land on the same clock edge. The bench provokes this by raising the selected trigger line and then placing the high-byte write exactly two clock edges later, which is the cycle in which the synchronized edge pulse is live. The written value differs from the previously committed pair. The check therefore passes only if `dac_out` shows the new byte, combined with the held low bits, right after that edge.

// File: rtl/dacb_pkg.sv
package dacb_pkg;
  localparam int ADDR_W  = 2;
  localparam int BYTE_W  = 8;
  localparam int DAC_W   = 10;
  localparam int LO_BITS = DAC_W - BYTE_W;
  localparam logic [ADDR_W-1:0] ADDR_LO = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HI = 2'd1;
endpackage

// File: rtl/dacb_hold.sv
module dacb_hold
  import dacb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              hi_wr_o,
  output logic [DAC_W-1:0]  pair_o
);
  logic [BYTE_W-1:0]  hi_q;
  logic [LO_BITS-1:0] lo_q;      // bus-visible low byte, only the used bits
  logic [LO_BITS-1:0] lo_cmt_q;  // low bits committed by the last high write
  logic               lo_wr;

  assign lo_wr   = wr_en && (wr_addr == ADDR_LO);
  assign hi_wr_o = wr_en && (wr_addr == ADDR_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      lo_q     <= '0;
      lo_cmt_q <= '0;
    end else begin
      if (lo_wr)   lo_q <= wr_data[BYTE_W-1 -: LO_BITS];
      if (hi_wr_o) begin
        hi_q     <= wr_data;
        lo_cmt_q <= lo_q;
      end
    end
  end

  // A high write in flight wins over the stored pair
  always_comb begin
    if (hi_wr_o) pair_o = {wr_data, lo_q};
    else         pair_o = {hi_q, lo_cmt_q};
  end

  // R8: a lone low write leaves the committed low bits alone
  p_lo_cmt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (lo_wr && !hi_wr_o) |=> $stable(lo_cmt_q));
  // R1: a high write commits the low bits held before it
  p_commit_r1: assert property (@(posedge clk) disable iff (rst)
    hi_wr_o |=> (lo_cmt_q == $past(lo_q)));
endmodule

// File: rtl/dacb_trig.sv
module dacb_trig #(
  parameter int NUM_TRIG = 8,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                pulse_o
);
  localparam int SEL_N = 1 << SEL_W;

  logic [SEL_N-1:0] edge_w;

  for (genvar i = 0; i < SEL_N; i++) begin : g_line
    if (i < NUM_TRIG) begin : g_used
      logic s1_q, s2_q, s3_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1_q <= 1'b0;
          s2_q <= 1'b0;
          s3_q <= 1'b0;
        end else begin
          s1_q <= trig_i[i];
          s2_q <= s1_q;
          s3_q <= s2_q;
        end
      end
      assign edge_w[i] = s2_q & ~s3_q;
    end else begin : g_unused
      assign edge_w[i] = 1'b0;
    end
  end

  assign pulse_o = edge_w[sel_i];

  // R6: one edge gives a single-cycle pulse
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !(pulse_o && $stable(sel_i)));
endmodule

// File: rtl/dac_dbuf.sv
module dac_dbuf
  import dacb_pkg::*;
#(
  parameter int NUM_TRIG = 8,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                trig_mode,
  input  logic [SEL_W-1:0]    trig_sel,
  input  logic [NUM_TRIG-1:0] trig_in,
  output logic [DAC_W-1:0]    dac_out
);
  logic             hi_wr;
  logic [DAC_W-1:0] pair;
  logic             trig_pulse;
  logic             load;

  dacb_hold i_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .hi_wr_o (hi_wr),
    .pair_o  (pair)
  );

  dacb_trig #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) i_trig (
    .clk     (clk),
    .rst     (rst),
    .trig_i  (trig_in),
    .sel_i   (trig_sel),
    .pulse_o (trig_pulse)
  );

  assign load = trig_mode ? trig_pulse : hi_wr;

  always_ff @(posedge clk) begin
    if (rst)       dac_out <= '0;
    else if (load) dac_out <= pair;
  end

  // R10: reset clears the shadow
  p_reset_zero_r10: assert property (@(posedge clk)
    rst |=> (dac_out == '0));
  // R3: immediate-mode high write shows the written byte in the upper bits
  p_imm_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!trig_mode && wr_en && wr_addr == ADDR_HI) |=> (dac_out[DAC_W-1 -: BYTE_W] == $past(wr_data)));
  // R4: a lone low write does not move the output
  p_lo_only_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_LO && !(trig_mode && trig_pulse)) |=> $stable(dac_out));
  // R5: in triggered mode a high write alone leaves the output
  p_trig_no_wr_r5: assert property (@(posedge clk) disable iff (rst)
    (trig_mode && wr_en && wr_addr == ADDR_HI && !trig_pulse) |=> $stable(dac_out));
  // R11: unmapped addresses change nothing
  p_bad_addr_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > ADDR_HI && !(trig_mode && trig_pulse)) |=> $stable(dac_out));
endmodule

// File: tb/test_dac_dbuf.sv
module test_dac_dbuf;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       trig_mode;
  logic [2:0] trig_sel;
  logic [7:0] trig_in;
  logic [9:0] dac_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dac_dbuf i_dac_dbuf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_mode(trig_mode), .trig_sel(trig_sel), .trig_in(trig_in), .dac_out(dac_out)
  );

  // Each vector: {address, data, expected output after the write}; immediate mode
  localparam int NV = 11;
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 8'hC0, 10'h000},  // R4 low alone
    {2'd1, 8'h12, 10'h04B},  // R3 R2
    {2'd1, 8'hFF, 10'h3FF},  // R3
    {2'd0, 8'h3F, 10'h3FF},  // R4
    {2'd1, 8'h00, 10'h000},  // R2 low bits 7:6 = 00
    {2'd2, 8'hAA, 10'h000},  // R11
    {2'd0, 8'h80, 10'h000},  // R4
    {2'd3, 8'h55, 10'h000},  // R11
    {2'd1, 8'hA5, 10'h296},  // R1 R3
    {2'd0, 8'h40, 10'h296},  // R4
    {2'd1, 8'h01, 10'h005}   // R3
  };

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: dac_out=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Raise a line, sample after edge k+2, then release and let it settle
  task automatic fire(input int line, input string req, input logic [9:0] exp);
    @(negedge clk);
    trig_in[line] = 1'b1;
    repeat (3) @(negedge clk);
    check(req, dac_out, exp);
    trig_in[line] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: dac_out=%h expected=done", dac_out);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    trig_mode = 1'b0; trig_sel = 3'd3; trig_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 reset", dac_out, 10'h000);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][19:18], VEC[i][17:10]);
      check($sformatf("R1-vec%0d", i), dac_out, VEC[i][9:0]);
    end

    // Triggered mode, line 3
    trig_mode = 1'b1;
    wr(2'd0, 8'hC0);
    wr(2'd1, 8'h9C);
    check("R5 hi write held", dac_out, 10'h005);
    fire(5, "R6 other line ignored", 10'h005);
    fire(3, "R6 selected edge loads", 10'h273);

    wr(2'd0, 8'h00);
    wr(2'd1, 8'h40);
    wr(2'd0, 8'hC0);
    check("R4 low in trig mode", dac_out, 10'h273);
    fire(3, "R8 late low unused / R7", 10'h100);

    // Level held high: one load only
    @(negedge clk); trig_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 level first load", dac_out, 10'h100);
    wr(2'd1, 8'h11);
    repeat (4) @(negedge clk);
    check("R6 level no reload", dac_out, 10'h100);
    trig_in[3] = 1'b0;
    repeat (4) @(negedge clk);

    // Same-cycle high write and trigger pulse
    @(negedge clk); trig_in[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h7E;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 same cycle", dac_out, 10'h1FB);
    trig_in[3] = 1'b0;
    repeat (4) @(negedge clk);

    // Different selection
    trig_sel = 3'd0;
    wr(2'd1, 8'h22);
    fire(3, "R6 deselected line", 10'h1FB);
    fire(0, "R6 line 0 selected", 10'h08B);

    // Writes during reset are dropped
    trig_mode = 1'b0;
    @(negedge clk); rst = 1'b1;
    wr(2'd1, 8'h77);
    @(negedge clk); rst = 1'b0;
    check("R10 reset write dropped", dac_out, 10'h000);
    wr(2'd1, 8'h01);
    check("R10 low cleared", dac_out, 10'h004);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule